// File: doc/BRIEF.md
# Selectable-Rate Countdown Timer

This block is an 8-bit periodic countdown timer for a real-time-clock style device. A free-running prescaler chain divides a base tick enable (nominally 4096 per second) down to three slower rates. A two-bit source code picks one of the four rates, and each tick of the chosen source decrements the counter while the timer is enabled. When the count passes through one to zero, the counter reloads its programmed value, so the timer runs periodically, and a sticky flag is raised.

Software reaches the block through a simple register write port. The timer-control register holds the source code and the run enable. The count register holds the period. Interrupt enable, output style and the flag-clear action share a second control register. The interrupt line either follows the flag, or gives one pulse per expiry that lasts one source period.

Top module: `cdtimer`

## Requirements
- R1: After reset the flag and the interrupt line are low, the timer is disabled, source code, count and period are zero, and both output modes are off.
- R2: The source code in bits 1:0 of the timer-control register (address 0xE) selects the decrement rate. Code 0 is every base tick. Code 1 is every DIV_FAST base ticks. Code 2 is every DIV_FAST*DIV_MID base ticks. Code 3 is every DIV_FAST*DIV_MID*DIV_SLOW base ticks. All counted from the first base tick after reset.
- R3: Bit 3 of the timer-control register enables counting. While it is clear the counter holds its value and no expiry occurs.
- R4: On an enabled source tick with the counter at 1, the flag is set in the next cycle and the counter reloads the programmed period. With a larger count, it decrements by one.
- R5: A write to the count register (address 0xF) always stores the period. While disabled it also loads the counter directly. While enabled the running count is left untouched.
- R6: A counter at 0 stays at 0 and never expires until it is loaded again.
- R7: The flag is sticky. A write to address 0x1 with bit 2 at 0 clears it. A write with bit 2 at 1 leaves it unchanged. An expiry in the same cycle as a clear leaves the flag set.
- R8: With bit 4 of address 0x1 at 0 (level mode), the interrupt line equals the flag ANDed with the interrupt enable in bit 0 of address 0x1.
- R9: With bit 4 of address 0x1 at 1 (pulse mode), the interrupt line is the interrupt enable ANDed with a pulse. The pulse rises in the cycle after an expiry and falls in the cycle after the next source tick that does not expire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| baseTick | input | 1 | Base oscillator tick enable, one cycle per tick |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address (0x1, 0xE, 0xF) |
| wrData | input | 8 | Register write data |
| timerFlag | output | 1 | Sticky expiry flag |
| irqOut | output | 1 | Interrupt line, level or pulse style |

## Verification
An expiry and a flag-clear write can fall in the same cycle. A reload and a write to the count register can also coincide with a decrementing tick. The bench sweeps every source code, both output styles and several periods, including zero and one. A period of one at the fastest source expires on most cycles, and the bench issues periodic clear writes and mid-run count writes, so these collisions happen many times. A cycle-exact arithmetic model of the flag and interrupt line, built from the base-tick count and the requirements, judges every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [3:0] ADDR_CTRL2 = 4'h1;
  localparam logic [3:0] ADDR_TCTRL = 4'hE;
  localparam logic [3:0] ADDR_COUNT = 4'hF;

  typedef struct packed {
    logic loadDirect;  // put write data into the running counter
    logic loadPeriod;  // put write data into the period register
    logic step;        // decrement by one
    logic reload;      // expiry: copy period into counter
  } tmr_strobe_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int unsigned DIV_FAST = 64,
  parameter int unsigned DIV_MID  = 64,
  parameter int unsigned DIV_SLOW = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  output logic [3:0] srcTicks
);
  localparam int unsigned STAGES = 3;
  localparam int unsigned DIVS [STAGES] = '{DIV_FAST, DIV_MID, DIV_SLOW};

  logic [STAGES:0] tickChain;
  assign tickChain[0] = baseTick;

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    localparam int unsigned W = (DIVS[g] > 2) ? $clog2(DIVS[g]) : 1;
    localparam logic [W-1:0] LAST = W'(DIVS[g] - 1);
    logic [W-1:0] stageCnt;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stageCnt <= '0;
      end else if (tickChain[g]) begin
        stageCnt <= (stageCnt == LAST) ? '0 : stageCnt + 1'b1;
      end
    end

    assign tickChain[g+1] = tickChain[g] && (stageCnt == LAST);

    // R2: a stage counter never holds a value beyond its divide ratio
    a_r2_stage_range: assert property (@(posedge clk) disable iff (!rstN)
      stageCnt <= LAST);
  end

  assign srcTicks = tickChain;
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmr_strobe_t   stb,
  input  logic [DW-1:0] wrData,
  output logic          cntIsZero,
  output logic          cntIsOne
);
  logic [DW-1:0] cnt;
  logic [DW-1:0] period;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      period <= '0;
    end else begin
      if (stb.loadPeriod) period <= wrData;
      if (stb.loadDirect)  cnt <= wrData;
      else if (stb.reload) cnt <= period;
      else if (stb.step)   cnt <= cnt - 1'b1;
    end
  end

  assign cntIsZero = (cnt == '0);
  assign cntIsOne  = (cnt == DW'(1));

  a_r5_direct_load: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadDirect |=> cnt == $past(wrData));
  a_r3_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.loadDirect || stb.reload || stb.step) |=> $stable(cnt));
  a_r6_zero_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (cntIsZero && !stb.loadDirect) |=> cntIsZero);
  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    (stb.reload && !stb.loadDirect) |=> cnt == $past(period));
endmodule

// File: rtl/tmr_control.sv
module tmr_control
  import tmr_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    srcTicks,
  input  logic          wrEn,
  input  logic [3:0]    wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic          cntIsZero,
  input  logic          cntIsOne,
  output tmr_strobe_t   stb,
  output logic          timerFlag,
  output logic          irqOut
);
  logic [1:0] srcSel;
  logic       runEn, tieEn, pulseMode, flagQ, pulseQ;

  logic wrCtrl2, wrTctrl, wrCount, srcTick, zeroHit, flagClear;
  assign wrCtrl2   = wrEn && (wrAddr == ADDR_CTRL2);
  assign wrTctrl   = wrEn && (wrAddr == ADDR_TCTRL);
  assign wrCount   = wrEn && (wrAddr == ADDR_COUNT);
  assign srcTick   = srcTicks[srcSel];
  assign zeroHit   = runEn && srcTick && cntIsOne;
  assign flagClear = wrCtrl2 && !wrData[2];

  always_comb begin
    stb            = '0;
    stb.reload     = zeroHit;
    stb.step       = runEn && srcTick && !cntIsZero && !cntIsOne;
    stb.loadDirect = wrCount && !runEn;
    stb.loadPeriod = wrCount;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcSel    <= 2'd0;
      runEn     <= 1'b0;
      tieEn     <= 1'b0;
      pulseMode <= 1'b0;
      flagQ     <= 1'b0;
      pulseQ    <= 1'b0;
    end else begin
      if (wrTctrl) begin
        srcSel <= wrData[1:0];
        runEn  <= wrData[3];
      end
      if (wrCtrl2) begin
        tieEn     <= wrData[0];
        pulseMode <= wrData[4];
      end
      if (zeroHit)        flagQ <= 1'b1;
      else if (flagClear) flagQ <= 1'b0;
      if (zeroHit)        pulseQ <= 1'b1;
      else if (srcTick)   pulseQ <= 1'b0;
    end
  end

  assign timerFlag = flagQ;
  assign irqOut    = tieEn && (pulseMode ? pulseQ : flagQ);

  a_r4_hit_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |=> timerFlag);
  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (timerFlag && !flagClear) |=> timerFlag);
  a_r7_no_spurious_set: assert property (@(posedge clk) disable iff (!rstN)
    (!timerFlag && !zeroHit) |=> !timerFlag);
  a_r9_pulse_after_hit: assert property (@(posedge clk) disable iff (!rstN)
    zeroHit |=> pulseQ);
  a_r3_no_hit_disabled: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |-> !(stb.reload || stb.step));
endmodule

// File: rtl/cdtimer.sv
module cdtimer
  import tmr_pkg::*;
#(
  parameter int unsigned DIV_FAST = 64,
  parameter int unsigned DIV_MID  = 64,
  parameter int unsigned DIV_SLOW = 60
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       baseTick,
  input  logic       wrEn,
  input  logic [3:0] wrAddr,
  input  logic [7:0] wrData,
  output logic       timerFlag,
  output logic       irqOut
);
  localparam int unsigned DW = 8;

  logic [3:0]  srcTicks;
  tmr_strobe_t stb;
  logic        cntIsZero, cntIsOne;

  tmr_prescaler #(.DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)) uPre (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .srcTicks(srcTicks)
  );

  tmr_control #(.DW(DW)) uCtl (
    .clk(clk), .rstN(rstN), .srcTicks(srcTicks), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cntIsZero(cntIsZero), .cntIsOne(cntIsOne), .stb(stb),
    .timerFlag(timerFlag), .irqOut(irqOut)
  );

  tmr_datapath #(.DW(DW)) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .cntIsZero(cntIsZero), .cntIsOne(cntIsOne)
  );
endmodule

// File: tb/cdtimer_test.sv
`timescale 1ns/1ps
module cdtimer_test;
  localparam int unsigned DA = 2;
  localparam int unsigned DB = 3;
  localparam int unsigned DC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic baseTick = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrAddr = 4'h0;
  logic [7:0] wrData = 8'h00;
  logic timerFlag, irqOut;

  int nChecks = 0;
  int nFails = 0;

  // reference state
  int nBase = 0;
  int mSrc = 0;
  bit mEn = 0, mTie = 0, mPm = 0, mFlag = 0, mPulse = 0;
  int mCnt = 0, mPer = 0;

  always #5 clk = ~clk;

  cdtimer #(.DIV_FAST(DA), .DIV_MID(DB), .DIV_SLOW(DC)) uut (
    .clk(clk), .rstN(rstN), .baseTick(baseTick), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .timerFlag(timerFlag), .irqOut(irqOut)
  );

  function automatic int srcPeriod(int s);
    case (s)
      0: return 1;
      1: return DA;
      2: return DA * DB;
      default: return DA * DB * DC;
    endcase
  endfunction

  task automatic check(string tag, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0b expected=%0b time=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic cycle(bit w, logic [3:0] a, logic [7:0] d, bit t);
    bit st, ev, wr1, wrE, wrF;
    int nCnt;
    @(negedge clk);
    wrEn = w; wrAddr = a; wrData = d; baseTick = t;
    if (t) nBase++;
    st  = t && ((nBase % srcPeriod(mSrc)) == 0);       // R2
    ev  = mEn && st && (mCnt == 1);                      // R4
    wr1 = w && (a == 4'h1);
    wrE = w && (a == 4'hE);
    wrF = w && (a == 4'hF);
    nCnt = mCnt;
    if (wrF && !mEn) nCnt = d;                           // R5
    else if (ev) nCnt = mPer;
    else if (mEn && st && mCnt > 1) nCnt = mCnt - 1;     // R3, R6
    mCnt = nCnt;
    if (wrF) mPer = d;
    if (ev) mFlag = 1;                                   // R7 set wins
    else if (wr1 && !d[2]) mFlag = 0;
    if (ev) mPulse = 1;
    else if (st) mPulse = 0;
    if (wrE) begin mSrc = d[1:0]; mEn = d[3]; end
    if (wr1) begin mTie = d[0]; mPm = d[4]; end
    @(posedge clk);
    #2;
    check("R2,R3,R4,R5,R6,R7 flag", timerFlag, mFlag);
    check("R8,R9 irq", irqOut, mTie && (mPm ? mPulse : mFlag));
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int periods[5] = '{1, 2, 3, 0, 7};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: reset state
    check("R1 flag", timerFlag, 1'b0);
    check("R1 irq", irqOut, 1'b0);
    for (int s = 0; s < 4; s++) begin
      for (int pm = 0; pm < 2; pm++) begin
        for (int pi = 0; pi < 5; pi++) begin
          logic [7:0] c2;
          c2 = 8'h01 | 8'(pm << 4);
          cycle(1, 4'hE, 8'(s), 0);                // disabled, source s
          cycle(1, 4'h1, c2, 0);                   // enable irq, clear flag
          cycle(1, 4'hF, 8'(periods[pi]), 0);      // R5 direct load
          cycle(1, 4'hE, 8'(8 | s), 0);            // R3 start
          for (int k = 1; k <= 130; k++) begin
            bit t;
            t = (k % 3) != 2;
            if (k == 60)           cycle(1, 4'hE, 8'(s), t);          // R3 stop
            else if (k == 66)      cycle(1, 4'hF, 8'(periods[pi]), t);
            else if (k == 80)      cycle(1, 4'hE, 8'(8 | s), t);
            else if (k == 105)     cycle(1, 4'h1, 8'(pm << 4), t);    // tie off
            else if (k == 115)     cycle(1, 4'h1, c2, t);
            else if (k % 17 == 0)  cycle(1, 4'h1, c2, t);             // R7 clear
            else if (k % 23 == 0)  cycle(1, 4'h1, c2 | 8'h04, t);     // R7 no clear
            else if (k % 29 == 0)  cycle(1, 4'hF, 8'((periods[pi] + k) % 5), t); // R5 running
            else                   cycle(0, 4'h0, 8'h00, t);
          end
        end
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule